// File: doc/BRIEF.md
# Alternating Step Keystream Generator

This block produces a pseudo-random keystream at one bit per enabled cycle. It holds three linear-feedback shift registers. Two of them are data registers (R0 and R1). The third is a control register (R2). The control register steps on every enabled cycle. The bit it presents before that step picks which data register steps with it; the other data register keeps its contents unchanged. Each output bit is the XOR of the two data registers' output cells after the cycle's step.

All stepping runs in one clock domain. It is gated by synchronous step enables, never by gating the clock. A small controller in three states tracks what the previous cycle did:
- **ST_IDLE**: the cycle was in reset or disabled.
- **ST_LOAD**: seeds were written.
- **ST_STREAM**: a keystream bit was produced.

Every state takes the same transitions each cycle:
- reset leads to ST_IDLE;
- otherwise `seed_load` leads to ST_LOAD;
- otherwise `en` leads to ST_STREAM;
- otherwise the controller goes to ST_IDLE.

`ks_valid` is high only in ST_STREAM. Software-style users load three seeds once and then strobe `en` whenever a keystream bit is wanted.

Top module: `asg_keygen`

## Requirements
- R1: A synchronous reset sets all three registers to the value 1 (only the LSB cell set) and drives `ks_valid` low in the following cycle. With the default lengths, `ks_bit` is therefore 0 after reset.
- R2: Each register is a Fibonacci LFSR. A step shifts the register one place toward the MSB and writes the XOR of its tapped cells into the LSB. The register's output bit is its MSB cell. The control register R2 steps on every cycle with `en`=1 and `seed_load`=0.
- R3: On an enabled cycle where R2's MSB, sampled before the step, is 0, R0 steps and R1 keeps every stored bit.
- R4: On an enabled cycle where R2's MSB, sampled before the step, is 1, R1 steps and R0 keeps every stored bit.
- R5: `ks_bit` always equals MSB(R0) XOR MSB(R1) of the current register contents. `ks_valid` is high in exactly the cycle after each enabled cycle, so the flagged bit reflects that cycle's conditional step.
- R6: A cycle with `en`=0 and `seed_load`=0 leaves all three registers unchanged and gives `ks_valid`=0 in the next cycle.
- R7: `seed_load`=1 writes `seed0`, `seed1` and `seed2` into R0, R1 and R2 in the same cycle. It takes priority over `en`, and `ks_valid` is 0 in the next cycle.
- R8: A seed of all zeros is stored as the value 1 instead, so no register can hold the all-zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Write all three seeds this cycle |
| seed0 | input | LEN0 | Seed for data register R0 |
| seed1 | input | LEN1 | Seed for data register R1 |
| seed2 | input | LEN2 | Seed for control register R2 |
| en | input | 1 | Produce one keystream bit this cycle |
| ks_bit | output | 1 | Keystream bit, MSB(R0) XOR MSB(R1) |
| ks_valid | output | 1 | `ks_bit` holds a freshly generated bit |

## Verification
The bench builds the block with its default parameters:
- R0 is 5 bits with taps at cells 5 and 3.
- R1 is 7 bits with taps at cells 7 and 6.
- R2 is 9 bits with taps at cells 9 and 5.

These short maximal-length registers wrap many times within a few thousand enabled cycles. The control register alone wraps every 511 steps. The bench therefore sees both data registers step from many different states, and sees long runs where one data register is frozen. Zero seeds, loads during `en`, and a mid-stream reset are all easy to reach at these sizes.

// File: rtl/asg_pkg.sv
package asg_pkg;

    // Activity of the previous cycle, as seen by the output decode
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_STREAM = 2'd2
    } asg_state_e;

    // Per-register step enables for one cycle
    typedef struct packed {
        logic r0;
        logic r1;
        logic r2;
    } asg_steps_t;

endpackage

// File: rtl/asg_lfsr.sv
module asg_lfsr #(
    parameter int            LEN  = 5,
    parameter logic [LEN-1:0] TAPS = {1'b1, {(LEN-1){1'b0}}},
    parameter logic [LEN-1:0] FILL = {{(LEN-1){1'b0}}, 1'b1}
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [LEN-1:0] seed,
    output logic [LEN-1:0] state,
    output logic           out_bit
);

    localparam int MSB = LEN - 1;

    logic [LEN-1:0] q;
    logic [LEN-1:0] shifted;
    logic [LEN-1:0] seed_fixed;
    logic           feedback;

    assign feedback = ^(q & TAPS);

    // Shift one place toward the MSB; fresh bit enters at the LSB
    assign shifted[0] = feedback;
    for (genvar i = 1; i < LEN; i++) begin : g_shift
        assign shifted[i] = q[i-1];
    end

    // An all-zero seed would freeze the register forever
    assign seed_fixed = (seed == '0) ? FILL : seed;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= FILL;
        end else if (load) begin
            q <= seed_fixed;
        end else if (step) begin
            q <= shifted;
        end
    end

    assign state   = q;
    assign out_bit = q[MSB];

endmodule

// File: rtl/asg_step_ctrl.sv
module asg_step_ctrl
    import asg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       load,
    input  logic       ctl_bit,
    output asg_steps_t steps,
    output logic       ks_valid
);

    asg_state_e state_q;
    asg_state_e state_d;
    logic       run;

    // Next state: every state shares the same transition rule
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_LOAD, ST_STREAM: begin
                if (load) begin
                    state_d = ST_LOAD;
                end else if (en) begin
                    state_d = ST_STREAM;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        ks_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   ks_valid = 1'b0;
            ST_LOAD:   ks_valid = 1'b0;
            ST_STREAM: ks_valid = 1'b1;
            default:   ks_valid = 1'b0;
        endcase
    end

    // Step gating: control always moves, one data register follows it
    assign run      = en && !load;
    assign steps.r2 = run;
    assign steps.r0 = run && !ctl_bit;
    assign steps.r1 = run &&  ctl_bit;

endmodule

// File: rtl/asg_keygen.sv
module asg_keygen
    import asg_pkg::*;
#(
    parameter int             LEN0  = 5,
    parameter int             LEN1  = 7,
    parameter int             LEN2  = 9,
    parameter logic [LEN0-1:0] TAPS0 = 5'b10100,
    parameter logic [LEN1-1:0] TAPS1 = 7'b1100000,
    parameter logic [LEN2-1:0] TAPS2 = 9'b100010000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            seed_load,
    input  logic [LEN0-1:0] seed0,
    input  logic [LEN1-1:0] seed1,
    input  logic [LEN2-1:0] seed2,
    input  logic            en,
    output logic            ks_bit,
    output logic            ks_valid
);

    asg_steps_t      steps;
    logic [LEN0-1:0] r0_q;
    logic [LEN1-1:0] r1_q;
    logic [LEN2-1:0] r2_q;
    logic            r0_out;
    logic            r1_out;
    logic            ctl_out;

    asg_step_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .load     (seed_load),
        .ctl_bit  (ctl_out),
        .steps    (steps),
        .ks_valid (ks_valid)
    );

    asg_lfsr #(.LEN(LEN0), .TAPS(TAPS0)) u_data0 (
        .clk     (clk),
        .rst     (rst),
        .load    (seed_load),
        .step    (steps.r0),
        .seed    (seed0),
        .state   (r0_q),
        .out_bit (r0_out)
    );

    asg_lfsr #(.LEN(LEN1), .TAPS(TAPS1)) u_data1 (
        .clk     (clk),
        .rst     (rst),
        .load    (seed_load),
        .step    (steps.r1),
        .seed    (seed1),
        .state   (r1_q),
        .out_bit (r1_out)
    );

    asg_lfsr #(.LEN(LEN2), .TAPS(TAPS2)) u_ctl (
        .clk     (clk),
        .rst     (rst),
        .load    (seed_load),
        .step    (steps.r2),
        .seed    (seed2),
        .state   (r2_q),
        .out_bit (ctl_out)
    );

    // Registers already hold post-step contents, so no extra pipeline stage
    assign ks_bit = r0_out ^ r1_out;

endmodule

// File: rtl/asg_keygen_chk.sv
module asg_keygen_chk #(
    parameter int             LEN0  = 5,
    parameter int             LEN1  = 7,
    parameter int             LEN2  = 9,
    parameter logic [LEN2-1:0] TAPS2 = 9'b100010000
) (
    input logic            clk,
    input logic            rst,
    input logic            en,
    input logic            seed_load,
    input logic [LEN0-1:0] seed0,
    input logic [LEN0-1:0] r0,
    input logic [LEN1-1:0] r1,
    input logic [LEN2-1:0] r2,
    input logic            ks_bit,
    input logic            ks_valid
);

    // R2
    ctl_steps_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_load) |=> r2 == {$past(r2[LEN2-2:0]), ^($past(r2) & TAPS2)});

    // R3
    r1_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_load && !r2[LEN2-1]) |=> $stable(r1));

    // R4
    r0_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_load && r2[LEN2-1]) |=> $stable(r0));

    // R5
    valid_follows_en_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_load) |=> ks_valid);

    // R5
    bit_matches_regs_chk: assert property (@(posedge clk) disable iff (rst)
        ks_bit == (r0[LEN0-1] ^ r1[LEN1-1]));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !seed_load) |=> ($stable(r0) && $stable(r1) && $stable(r2) && !ks_valid));

    // R7
    load_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> !ks_valid);

    // R8
    zero_seed_fix_chk: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed0 == '0) |=> r0 == LEN0'(1));

    // R8
    no_lockup_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (r0 != '0 && r1 != '0 && r2 != '0));

endmodule

bind asg_keygen asg_keygen_chk #(
    .LEN0 (LEN0),
    .LEN1 (LEN1),
    .LEN2 (LEN2),
    .TAPS2(TAPS2)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .seed_load(seed_load),
    .seed0    (seed0),
    .r0       (r0_q),
    .r1       (r1_q),
    .r2       (r2_q),
    .ks_bit   (ks_bit),
    .ks_valid (ks_valid)
);

// File: tb/tb_asg_keygen.sv
`timescale 1ns/1ps
module tb_asg_keygen;

    localparam int L0 = 5;
    localparam int L1 = 7;
    localparam int L2 = 9;
    localparam logic [31:0] T0 = 32'h14;   // cells 5,3
    localparam logic [31:0] T1 = 32'h60;   // cells 7,6
    localparam logic [31:0] T2 = 32'h110;  // cells 9,5

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          seed_load = 1'b0;
    logic [L0-1:0] seed0 = '0;
    logic [L1-1:0] seed1 = '0;
    logic [L2-1:0] seed2 = '0;
    logic          en = 1'b0;
    logic          ks_bit;
    logic          ks_valid;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic  v;
        logic  b;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    logic [31:0] m0, m1, m2;

    always #4 clk = ~clk;

    asg_keygen dut (
        .clk(clk), .rst(rst), .seed_load(seed_load),
        .seed0(seed0), .seed1(seed1), .seed2(seed2),
        .en(en), .ks_bit(ks_bit), .ks_valid(ks_valid)
    );

    function automatic logic [31:0] fstep(input logic [31:0] s, input logic [31:0] taps, input int len);
        logic fb;
        logic [31:0] mask;
        fb   = ^(s & taps);
        mask = (32'h1 << len) - 32'h1;
        return ((s << 1) | {31'b0, fb}) & mask;
    endfunction

    function automatic logic [31:0] fix(input logic [31:0] s);
        return (s == 32'h0) ? 32'h1 : s;
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic drive(input logic r, input logic ld, input logic e,
                         input logic [L0-1:0] s0, input logic [L1-1:0] s1, input logic [L2-1:0] s2);
        exp_t x;
        logic c;
        @(negedge clk);
        rst = r; seed_load = ld; en = e; seed0 = s0; seed1 = s1; seed2 = s2;
        if (r) begin
            m0 = 1; m1 = 1; m2 = 1; x.v = 1'b0; x.tag = "R1";
        end else if (ld) begin
            m0 = fix({27'b0, s0}); m1 = fix({25'b0, s1}); m2 = fix({23'b0, s2});
            x.v = 1'b0;
            x.tag = (s0 == '0 || s1 == '0 || s2 == '0) ? "R8" : "R7";
        end else if (e) begin
            c  = m2[L2-1];
            m2 = fstep(m2, T2, L2);
            if (c) begin
                m1 = fstep(m1, T1, L1); x.tag = "R4 R2";
            end else begin
                m0 = fstep(m0, T0, L0); x.tag = "R3 R2";
            end
            x.v = 1'b1;
        end else begin
            x.v = 1'b0; x.tag = "R6";
        end
        x.b = m0[L0-1] ^ m1[L1-1];
        exp_q.push_back(x);
    endtask

    // Monitor: compare design output after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t x;
                x = exp_q.pop_front();
                checks++;
                if (ks_valid !== x.v) begin
                    failures++;
                    $display("FAIL %s/R5 ks_valid got %0b exp %0b", x.tag, ks_valid, x.v);
                end
                checks++;
                if (ks_bit !== x.b) begin
                    failures++;
                    $display("FAIL %s/R5 ks_bit got %0b exp %0b", x.tag, ks_bit, x.b);
                end
            end
        end
    end

    initial begin
        m0 = 1; m1 = 1; m2 = 1;
        // R1: reset state
        for (int i = 0; i < 3; i++) drive(1, 0, 0, '0, '0, '0);
        // R2 R3 R4 R5: stream from reset values
        for (int i = 0; i < 600; i++) drive(0, 0, 1, '0, '0, '0);
        // R7: load with en high, load wins
        drive(0, 1, 1, 5'h13, 7'h55, 9'h1A5);
        for (int i = 0; i < 300; i++) drive(0, 0, 1, '0, '0, '0);
        // R6: disabled stretch, registers must hold
        for (int i = 0; i < 20; i++) drive(0, 0, 0, 5'h1F, 7'h7F, 9'h1FF);
        for (int i = 0; i < 100; i++) drive(0, 0, 1, '0, '0, '0);
        // R8: all-zero seeds
        drive(0, 1, 0, '0, '0, '0);
        for (int i = 0; i < 200; i++) drive(0, 0, 1, '0, '0, '0);
        drive(0, 1, 1, 5'h0A, '0, 9'h100);
        for (int i = 0; i < 200; i++) drive(0, 0, 1, '0, '0, '0);
        // R1: reset in the middle of streaming
        drive(1, 0, 1, '0, '0, '0);
        for (int i = 0; i < 50; i++) drive(0, 0, 1, '0, '0, '0);
        // Mixed random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            drive(0, (r[7:0] == 8'h00), r[8] | r[9], L0'(r[20:16]), L1'(r[27:21]), L2'($urandom));
        end
        for (int i = 0; i < 4; i++) drive(0, 0, 0, '0, '0, '0);
        @(posedge clk);
        #3;
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R5 pending items got %0d exp 0", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R5 got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule